// File: doc/BRIEF.md
# Pulse width capture timer

This block measures how long a selected digital input stays high and gives the result to software through four byte-wide registers. One of four capture inputs is chosen by a select field. The chosen input is resynchronised to the bus clock, and its rising edge restarts a 16-bit counter. The counter advances on a count tick. The tick comes either from the bus clock or from an alternative clock input, and is then divided by a power-of-two prescaler. On the falling edge the count is latched as the result and a ready flag is raised.

The alternative clock is treated as asynchronous. It passes through a synchroniser and a rising-edge detector, so every flop of the block stays in the bus clock domain. The alternative clock may run at up to a quarter of the bus rate. A pulse too short to collect a single tick yields a zero count. Such a pulse is dropped: no result is latched and no status changes. A pulse too long for the counter stops at the top value and raises a sticky overflow flag.

Top module: `pwcap_timer`

## Requirements
- R1: After reset all four registers read 0x00: status (address 0), control (address 1), result high byte (address 2) and result low byte (address 3).
- R2: Control bits [1:0] select which of cap_in[3:0] is measured. Pulses on the other inputs latch nothing.
- R3: With control bit 2 = 0 (bus clock source) and prescale exponent N in control bits [5:3], a pulse high for H bus-clock samples gives a result of floor((H-1)/2^N).
- R4: A pulse whose count is zero latches nothing. The ready flag and the result registers keep their values.
- R5: Status bit 7 (ready) goes to 1 on the third rising clock edge after the first edge at which the input is sampled low. Writing 1 to bit 7 clears it, and writing 0 leaves it set.
- R6: A read strobe (bus_rd) at address 2 returns the high byte and copies the current low byte into a holding register. Address 3 returns that holding register, not the live low byte.
- R7: The counter stops at 0xFFFF instead of wrapping. A tick that arrives at 0xFFFF sets status bit 6 (overflow). This bit stays set until a 1 is written to bit 6.
- R8: With control bit 2 = 1, the count advances once per synchronised rising edge of alt_clk, divided by 2^N. If alt_clk is idle, a pulse counts nothing and latches nothing.
- R9: Status bit 0 is a run enable. While it is 0, pulses are not measured and the ready flag stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_in | input | 4 | Capture inputs, asynchronous |
| alt_clk | input | 1 | Alternative count clock, asynchronous, at most a quarter of the bus rate |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, used to capture the low byte on a high-byte read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The result and the ready flag update on the third rising edge after the first edge that samples the input low. Two of those edges are synchroniser stages and the third is the latch. The bench therefore checks the ready flag as still clear two edges after the fall, checks it as set one edge later, and reads the result only after that edge. Register reads are combinational, so the bench samples them one time step after it sets the address, away from any edge. The holding register for the low byte loads on the edge that ends a strobed high-byte read, so it is checked after a second pulse has replaced the live result.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 3;
  localparam int DIV_W  = (1 << PRE_W) - 1;
  localparam int SYNC_N = 2;

  localparam logic [1:0] A_STAT   = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_RES_HI = 2'd2;
  localparam logic [1:0] A_RES_LO = 2'd3;

  typedef struct packed {
    logic [1:0]       spare;
    logic [PRE_W-1:0] pre_exp;
    logic             alt_src;
    logic [1:0]       in_sel;
  } ctrl_t;

  // low N bits set: a tick falls where the prescale counter matches this
  function automatic logic [DIV_W-1:0] div_mask(input logic [PRE_W-1:0] e);
    logic [DIV_W:0] one_hot;
    one_hot  = {{DIV_W{1'b0}}, 1'b1} << e;
    div_mask = DIV_W'(one_hot - 1'b1);
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    sat_inc = (v == '1) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/pwcap_tick.sv
module pwcap_tick
  import pwcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alt_clk,
  input  logic             alt_src,
  input  logic [PRE_W-1:0] pre_exp,
  input  logic             restart,
  output logic             tick
);
  logic [SYNC_N:0]    alt_q;
  logic               alt_rise;
  logic               src_en;
  logic [DIV_W-1:0]   pre_cnt;
  logic [DIV_W-1:0]   mask;

  always_ff @(posedge clk) begin
    if (!rst_n) alt_q <= '0;
    else        alt_q <= {alt_q[SYNC_N-1:0], alt_clk};
  end

  assign alt_rise = alt_q[SYNC_N-1] & ~alt_q[SYNC_N];
  assign src_en   = alt_src ? alt_rise : 1'b1;
  assign mask     = div_mask(pre_exp);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pre_cnt <= '0;
    else if (src_en)       pre_cnt <= pre_cnt + 1'b1;
  end

  assign tick = src_en && !restart && ((pre_cnt & mask) == mask);

  p_tick_needs_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_src && !alt_rise) |-> !tick);
endmodule

// File: rtl/pwcap_meas.sv
module pwcap_meas
  import pwcap_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int SEL_W = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [N_IN-1:0]  cap_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             tick,
  output logic             start,
  output logic             busy,
  output logic             done,
  output logic             ovf_evt,
  output logic [CNT_W-1:0] cnt
);
  logic [SYNC_N:0] pin_q;
  logic            rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= {pin_q[SYNC_N-1:0], cap_in[sel]};
  end

  assign rise    = pin_q[SYNC_N-1] & ~pin_q[SYNC_N];
  assign fall    = ~pin_q[SYNC_N-1] & pin_q[SYNC_N];
  assign start   = run & rise & ~busy;
  assign done    = busy & fall & (cnt != '0);
  assign ovf_evt = busy & ~fall & tick & (cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!run) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (fall)      busy <= 1'b0;
      else if (tick) cnt  <= sat_inc(cnt);
    end
  end

  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && !start) |=> $stable(cnt));
  p_count_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (cnt >= $past(cnt)));
  p_count_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == '1 && !start) |=> (cnt == '1));
  p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done);
endmodule

// File: rtl/pwcap_timer.sv
module pwcap_timer
  import pwcap_pkg::*;
#(
  parameter int N_IN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] cap_in,
  input  logic            alt_clk,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata
);
  localparam int SEL_W = $clog2(N_IN);

  ctrl_t            ctrl_q;
  logic             run_q, rdy_q, ovf_q;
  logic [CNT_W-1:0] res_q;
  logic [7:0]       snap_q;
  logic             wr_stat, wr_ctrl, rd_hi;
  logic             tick, start, busy, done, ovf_evt;
  logic [CNT_W-1:0] cnt;

  assign wr_stat = bus_wr && bus_addr == A_STAT;
  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign rd_hi   = bus_rd && !bus_wr && bus_addr == A_RES_HI;

  pwcap_tick u_tick (
    .clk(clk), .rst_n(rst_n), .alt_clk(alt_clk), .alt_src(ctrl_q.alt_src),
    .pre_exp(ctrl_q.pre_exp), .restart(start), .tick(tick)
  );

  pwcap_meas #(.N_IN(N_IN)) u_meas (
    .clk(clk), .rst_n(rst_n), .run(run_q), .cap_in(cap_in),
    .sel(SEL_W'(ctrl_q.in_sel)), .tick(tick), .start(start), .busy(busy),
    .done(done), .ovf_evt(ovf_evt), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      run_q  <= 1'b0;
      rdy_q  <= 1'b0;
      ovf_q  <= 1'b0;
      res_q  <= '0;
      snap_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= {2'b00, bus_wdata[5:0]};
      if (wr_stat) run_q  <= bus_wdata[0];
      if (done)                        rdy_q <= 1'b1;
      else if (wr_stat && bus_wdata[7]) rdy_q <= 1'b0;
      if (ovf_evt)                     ovf_q <= 1'b1;
      else if (wr_stat && bus_wdata[6]) ovf_q <= 1'b0;
      if (done)  res_q  <= cnt;
      if (rd_hi) snap_q <= res_q[7:0];
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_STAT:   bus_rdata = {rdy_q, ovf_q, 5'b0, run_q};
      A_CTRL:   bus_rdata = ctrl_q;
      A_RES_HI: bus_rdata = res_q[15:8];
      default:  bus_rdata = snap_q;
    endcase
  end

  p_ready_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rdy_q);
  p_ready_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> (res_q != '0));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(wr_stat && bus_wdata[6])) |=> ovf_q);
  p_snap_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> (snap_q == $past(res_q[7:0])));
endmodule

// File: tb/tb_pwcap_timer.sv
`timescale 1ns/1ps
module tb_pwcap_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cap_in = '0;
  logic       alt_clk = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int  errors = 0;
  int  checks = 0;
  bit  finished = 1'b0;
  bit  alt_run = 1'b0;

  always #2.5 clk = ~clk;

  pwcap_timer dut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .alt_clk(alt_clk),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // alt clock: period of 8 bus cycles while enabled
  initial forever begin
    repeat (4) @(negedge clk);
    if (alt_run) alt_clk = ~alt_clk;
  end

  typedef struct packed {
    logic [1:0]  sel;
    logic [2:0]  pre;
    logic [15:0] high;
    logic [15:0] expect_w;
  } vec_t;

  // expected = floor((high-1)/2^pre)
  localparam vec_t VECS [8] = '{
    '{2'd0, 3'd0, 16'd10,  16'd9},
    '{2'd1, 3'd0, 16'd37,  16'd36},
    '{2'd2, 3'd1, 16'd20,  16'd9},
    '{2'd3, 3'd2, 16'd33,  16'd8},
    '{2'd0, 3'd3, 16'd100, 16'd12},
    '{2'd1, 3'd7, 16'd300, 16'd2},
    '{2'd2, 3'd0, 16'd2,   16'd1},
    '{2'd3, 3'd2, 16'd5,   16'd1}
  };

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  // strobed high read then low read: returns the 16-bit result
  task automatic rd16(output logic [15:0] v);
    logic [7:0] h, l;
    @(negedge clk);
    bus_addr = 2'd2; bus_rd = 1'b1;
    #0.5; h = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    peek(2'd3, l);
    v = {h, l};
  endtask

  task automatic pulse(input int idx, input int high);
    @(negedge clk);
    cap_in[idx] = 1'b1;
    repeat (high) @(negedge clk);
    cap_in[idx] = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic stat(output logic [7:0] s);
    @(negedge clk);
    peek(2'd0, s);
  endtask

  initial begin
    logic [7:0]  s;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), s);
      check($sformatf("R1 reg %0d reset", a), s, 8'h00);
    end

    // R9 disabled: nothing measured
    pulse(0, 10);
    stat(s);
    check("R9 ready stays clear when off", s[7], 0);
    rd16(v);
    check("R9 result untouched when off", v, 0);

    wr(2'd0, 8'h01);

    // table walk: R2/R3 selection and width, R5 ready
    foreach (VECS[i]) begin
      wr(2'd1, {2'b00, VECS[i].pre, 1'b0, VECS[i].sel});
      wr(2'd0, 8'h81);
      pulse(int'(VECS[i].sel), int'(VECS[i].high));
      stat(s);
      check($sformatf("R5 ready vec %0d", i), s[7], 1);
      rd16(v);
      check($sformatf("R3 width vec %0d", i), v, VECS[i].expect_w);
    end

    // R2: other inputs ignored
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h81);
    pulse(0, 20);
    pulse(2, 20);
    stat(s);
    check("R2 unselected inputs ignored", s[7], 0);

    // R4: zero-count pulses dropped, result kept
    wr(2'd1, 8'h00);
    pulse(0, 30);
    wr(2'd0, 8'h81);
    pulse(0, 1);
    stat(s);
    check("R4 one-sample pulse ready", s[7], 0);
    wr(2'd1, 8'h10);
    pulse(0, 4);
    stat(s);
    check("R4 sub-tick pulse ready", s[7], 0);
    rd16(v);
    check("R4 result kept", v, 29);

    // R5 exact timing and write-1-to-clear
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h81);
    @(negedge clk);
    cap_in[0] = 1'b1;
    repeat (12) @(negedge clk);
    cap_in[0] = 1'b0;
    repeat (2) @(negedge clk);
    peek(2'd0, s);
    check("R5 ready not before third edge", s[7], 0);
    @(negedge clk);
    peek(2'd0, s);
    check("R5 ready on third edge", s[7], 1);
    wr(2'd0, 8'h01);
    stat(s);
    check("R5 write 0 keeps ready", s[7], 1);
    wr(2'd0, 8'h81);
    stat(s);
    check("R5 write 1 clears ready", s, 8'h01);

    // R6 coherent low byte
    rd16(v);
    check("R6 first read", v, 11);
    pulse(0, 7);
    peek(2'd3, s);
    check("R6 low byte is held copy", s, 8'd11);
    rd16(v);
    check("R6 new read", v, 6);

    // R8 alt clock source
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h81);
    pulse(1'b0, 40);
    stat(s);
    check("R8 idle alt clock latches nothing", s[7], 0);
    alt_run = 1'b1;
    repeat (16) @(negedge clk);
    pulse(0, 80);
    rd16(v);
    checks++;
    if (v < 9 || v > 11) begin
      errors++;
      $display("FAIL R8 alt count: got %0d expected 9..11", v);
    end
    alt_run = 1'b0;

    // R7 saturation and overflow flag
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h81);
    pulse(0, 65540);
    rd16(v);
    check("R7 saturated result", v, 16'hFFFF);
    stat(s);
    check("R7 overflow set", s[6], 1);
    wr(2'd0, 8'h01);
    stat(s);
    check("R7 overflow sticky", s[6], 1);
    wr(2'd0, 8'h41);
    stat(s);
    check("R7 overflow cleared", s[6], 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule